// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This block holds two programmable count engines that share one byte-wide register port. Each engine counts either an internal machine tick, which is one pulse every twelve clocks, or falling edges on its own external count pin. Each engine can also be held off by a run bit and, if its gate option is set, by a level on its own gate pin. A per-engine mode field selects how the two count bytes are chained: a 13-bit count, a full 16-bit count, an 8-bit count that reloads from the high byte, or, for engine 0 only, two independent 8-bit counts.

When a count wraps to zero it sets an overflow flag. The flag drives an output line that an interrupt controller can use. The flag clears when the matching acknowledge input pulses. Software sets up the engines through six byte addresses. A write to a count byte wins over any increment of that engine in the same cycle.

Top module: `dual_tc_unit`

## Requirements
- R1: A machine tick occurs once every CLK_PER_MC (default 12) clocks, starting with the 12th clock after reset. In timer source (ext_src=0), an enabled engine advances by one on each tick.
- R2: In pin source (ext_src=1), the count pin is sampled on each tick. An enabled engine advances by one on a tick whose sample is 0 when the previous tick's sample was 1. This gives at most one count per two ticks.
- R3: An engine is enabled when its run bit is 1 and either its gate bit is 0 or its gate pin is 1. Otherwise its count holds.
- R4: Mode field 00 (13-bit): the low byte bits [4:0] count and carry into the high byte. Low byte bits [7:5] are never changed by counting. Overflow occurs when the high byte is 0xFF and low bits [4:0] are 0x1F.
- R5: Mode field 01 (16-bit): {high, low} counts as one value. Overflow occurs on the wrap from 0xFFFF to 0x0000.
- R6: Mode field 10 (reload): the low byte counts. When it wraps from 0xFF, it takes the high byte value instead and overflow occurs. The high byte does not change.
- R7: Mode field 11 on engine 0 (split): the engine 0 low byte counts as an 8-bit engine under engine 0's own run, gate and source settings, and its wrap sets flag 0. The engine 0 high byte counts ticks whenever run bit 1 is set, and its wrap sets flag 1. Engine 1's own overflows set no flag while engine 0 is split.
- R8: Mode field 11 on engine 1: engine 1 holds its count.
- R9: A flag is set one clock after an overflow and clears one clock after its ack_i bit is 1. If an overflow and an ack happen in the same cycle, the set wins. ovf_o[k] shows flag k.
- R10: A write to either count byte of an engine loads that byte and suppresses that engine's increment, including the split high byte, in that cycle.
- R11: The register map is as follows. Address 0 holds the mode byte: engine 0 config in bits [3:0] and engine 1 config in bits [7:4], each laid out as {gate, ext_src, mode[1:0]}. Address 1 holds run0 in bit 0 and run1 in bit 1; flag0 and flag1 read back in bits 4 and 5 and cannot be written. Addresses 2 and 3 are the engine 0 low and high bytes, and addresses 4 and 5 are the engine 1 low and high bytes. All other addresses and bits read 0. Reads are combinational, and writes take effect at the next clock.
- R12: After reset, every register, flag and output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW (3) | Register address |
| wdata_i | input | DW (8) | Write data |
| rdata_o | output | DW (8) | Read data for addr_i |
| cnt_pin_i | input | 2 | External count pins, one per engine |
| gate_pin_i | input | 2 | External gate pins, one per engine |
| ack_i | input | 2 | Overflow acknowledge, one per engine |
| ovf_o | output | 2 | Overflow flags |

## Verification
Timer source runs in each chaining mode are started near the wrap point. These runs separate the 13-bit carry, the 16-bit wrap and the reload, and show whether the unused low bits stay put. The count pin is driven in four ways: slow square waves, waves at exactly the two-tick limit, toggling on every clock (which the once-per-tick sampling must alias), and uneven duty. These patterns tell real falling edges from the edges that sampling hides. Gate-low, gate-high and run-off stretches separate the two enable terms. A long random stretch of register writes, pin activity and acks then hits write-versus-increment collisions, mode changes mid-count and acks that land on a set.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    MODE_W13    = 2'b00,
    MODE_W16    = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_SPLIT  = 2'b11
  } tc_mode_e;

  typedef struct packed {
    logic     gate;
    logic     ext_src;
    tc_mode_e mode;
  } tc_cfg_t;

  localparam int unsigned CFG_W = $bits(tc_cfg_t);

  localparam logic [2:0] ADDR_CFG   = 3'd0;
  localparam logic [2:0] ADDR_CTRL  = 3'd1;
  localparam logic [2:0] ADDR_T0_LO = 3'd2;
  localparam logic [2:0] ADDR_T0_HI = 3'd3;
  localparam logic [2:0] ADDR_T1_LO = 3'd4;
  localparam logic [2:0] ADDR_T1_HI = 3'd5;
endpackage

// File: rtl/tc_tick_gen.sv
module tc_tick_gen #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tc_pin_edge.sv
module tc_pin_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic pin_i,
  output logic fall_o
);
  logic last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_q <= 1'b0;
    else if (sample_i) last_q <= pin_i;
  end

  assign fall_o = sample_i & last_q & ~pin_i;

  // R2: an edge consumes the high sample, so the next one needs a fresh high
  fall_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !last_q);
endmodule

// File: rtl/tc_counter.sv
module tc_counter
  import tc_pkg::*;
#(
  parameter int unsigned BW       = 8,
  parameter bit          SPLIT_OK = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  tc_mode_e      mode_i,
  input  logic          inc_i,
  input  logic          inc_hi_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] lo_o,
  output logic [BW-1:0] hi_o,
  output logic          ovf_o,
  output logic          ovf_hi_o
);
  localparam int unsigned W13_LO = 5;

  logic [BW-1:0] lo_q, hi_q, lo_d, hi_d;
  logic          split, wr_any;

  if (SPLIT_OK) begin : g_split
    assign split = (mode_i == MODE_SPLIT);
  end else begin : g_nosplit
    assign split = 1'b0;
  end

  assign wr_any = wr_lo_i | wr_hi_i;

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf_o    = 1'b0;
    ovf_hi_o = 1'b0;
    if (wr_any) begin
      if (wr_lo_i) lo_d = wdata_i;
      if (wr_hi_i) hi_d = wdata_i;
    end else if (split) begin
      if (inc_i) begin
        lo_d  = lo_q + 1'b1;
        ovf_o = &lo_q;
      end
      if (inc_hi_i) begin
        hi_d     = hi_q + 1'b1;
        ovf_hi_o = &hi_q;
      end
    end else if (inc_i) begin
      unique case (mode_i)
        MODE_W13: begin
          lo_d[W13_LO-1:0] = lo_q[W13_LO-1:0] + 1'b1;
          if (&lo_q[W13_LO-1:0]) begin
            hi_d  = hi_q + 1'b1;
            ovf_o = &hi_q;
          end
        end
        MODE_W16: begin
          {hi_d, lo_d} = {hi_q, lo_q} + 1'b1;
          ovf_o        = &{hi_q, lo_q};
        end
        MODE_RELOAD: begin
          if (&lo_q) begin
            lo_d  = hi_q;
            ovf_o = 1'b1;
          end else begin
            lo_d = lo_q + 1'b1;
          end
        end
        default: ;  // split on an engine that cannot split: hold
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  // R10
  wr_lo_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> lo_q == $past(wdata_i));

  // R5
  w16_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_any && mode_i == MODE_W16 && inc_i && !(&{hi_q, lo_q}))
    |=> {hi_q, lo_q} == $past({hi_q, lo_q}) + 1'b1);

  // R6
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_any && mode_i == MODE_RELOAD && inc_i && &lo_q)
    |=> (lo_q == $past(hi_q)) && $stable(hi_q));

  // R4
  w13_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_any && mode_i == MODE_W13) |=> $stable(lo_q[BW-1:W13_LO]));

  if (!SPLIT_OK) begin : g_hold_chk
    // R8
    split_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_any && mode_i == MODE_SPLIT) |=> $stable(lo_q) && $stable(hi_q));
  end
endmodule

// File: rtl/dual_tc_unit.sv
module dual_tc_unit
  import tc_pkg::*;
#(
  parameter int unsigned CLK_PER_MC = 12,
  parameter int unsigned AW         = 3,
  parameter int unsigned DW         = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [1:0]    cnt_pin_i,
  input  logic [1:0]    gate_pin_i,
  input  logic [1:0]    ack_i,
  output logic [1:0]    ovf_o
);
  localparam int unsigned NT = 2;

  tc_cfg_t       cfg_q [NT];
  logic [NT-1:0] run_q, flag_q, evt, fall, en, inc, inc_hi, ovf_lo, ovf_hi;
  logic [NT-1:0] wr_lo, wr_hi;
  logic [DW-1:0] lo_w [NT];
  logic [DW-1:0] hi_w [NT];
  logic          tick, split0, wr_cfg, wr_ctrl;

  tc_tick_gen #(.DIV(CLK_PER_MC)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  assign wr_cfg  = wr_en_i && (addr_i == AW'(ADDR_CFG));
  assign wr_ctrl = wr_en_i && (addr_i == AW'(ADDR_CTRL));
  assign wr_lo[0] = wr_en_i && (addr_i == AW'(ADDR_T0_LO));
  assign wr_hi[0] = wr_en_i && (addr_i == AW'(ADDR_T0_HI));
  assign wr_lo[1] = wr_en_i && (addr_i == AW'(ADDR_T1_LO));
  assign wr_hi[1] = wr_en_i && (addr_i == AW'(ADDR_T1_HI));
  assign split0   = (cfg_q[0].mode == MODE_SPLIT);

  for (genvar k = 0; k < NT; k++) begin : g_eng
    tc_pin_edge u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sample_i(tick),
      .pin_i   (cnt_pin_i[k]),
      .fall_o  (fall[k])
    );

    assign en[k]     = run_q[k] && (!cfg_q[k].gate || gate_pin_i[k]);
    assign inc[k]    = en[k] && (cfg_q[k].ext_src ? fall[k] : tick);
    assign inc_hi[k] = (k == 0) ? (tick & run_q[1]) : 1'b0;

    tc_counter #(.BW(DW), .SPLIT_OK(k == 0)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .mode_i  (cfg_q[k].mode),
      .inc_i   (inc[k]),
      .inc_hi_i(inc_hi[k]),
      .wr_lo_i (wr_lo[k]),
      .wr_hi_i (wr_hi[k]),
      .wdata_i (wdata_i),
      .lo_o    (lo_w[k]),
      .hi_o    (hi_w[k]),
      .ovf_o   (ovf_lo[k]),
      .ovf_hi_o(ovf_hi[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[k] <= 1'b0;
      else if (evt[k])   flag_q[k] <= 1'b1;
      else if (ack_i[k]) flag_q[k] <= 1'b0;
    end

    // R9
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt[k] |=> ovf_o[k]);
    // R9
    flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[k] && !evt[k]) |=> !ovf_o[k]);
  end

  // engine 1 wraps are masked while engine 0 borrows flag 1
  assign evt[0] = ovf_lo[0];
  assign evt[1] = split0 ? ovf_hi[0] : (ovf_lo[1] | ovf_hi[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q[0] <= '0;
      cfg_q[1] <= '0;
      run_q    <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_q[0] <= tc_cfg_t'(wdata_i[CFG_W-1:0]);
        cfg_q[1] <= tc_cfg_t'(wdata_i[2*CFG_W-1:CFG_W]);
      end
      if (wr_ctrl) run_q <= wdata_i[NT-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(ADDR_CFG):   rdata_o = {cfg_q[1], cfg_q[0]};
      AW'(ADDR_CTRL):  rdata_o = {2'b00, flag_q, 2'b00, run_q};
      AW'(ADDR_T0_LO): rdata_o = lo_w[0];
      AW'(ADDR_T0_HI): rdata_o = hi_w[0];
      AW'(ADDR_T1_LO): rdata_o = lo_w[1];
      AW'(ADDR_T1_HI): rdata_o = hi_w[1];
      default:         rdata_o = '0;
    endcase
  end

  assign ovf_o = flag_q;

  // R3
  t1_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en[1] && !wr_lo[1] && !wr_hi[1]) |=> $stable(lo_w[1]) && $stable(hi_w[1]));

  // R7
  split_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split0 && tick && run_q[1] && !wr_lo[0] && !wr_hi[0])
    |=> hi_w[0] == $past(hi_w[0]) + 1'b1);
endmodule

// File: tb/dual_tc_unit_tb.sv
module dual_tc_unit_tb_top;
  localparam int MC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] cnt_pin = '0;
  logic [1:0] gate_pin = '0;
  logic [1:0] ack = '0;
  logic [1:0] ovf;

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R12";

  always #5 clk = ~clk;

  dual_tc_unit dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .cnt_pin_i (cnt_pin),
    .gate_pin_i(gate_pin),
    .ack_i     (ack),
    .ovf_o     (ovf)
  );

  // ---------------- reference model ----------------
  int       pc;
  bit       last [2];
  int       tl [2];
  int       th [2];
  bit       fl [2];
  bit       run [2];
  bit [3:0] cfg [2];

  task automatic adv(input int k, input int m, output bit o);
    int v;
    o = 0;
    case (m)
      0: if ((tl[k] & 31) == 31) begin
           tl[k] = tl[k] & 224;
           o = (th[k] == 255);
           th[k] = (th[k] + 1) % 256;
         end else tl[k] = tl[k] + 1;
      1: begin
           v = th[k] * 256 + tl[k] + 1;
           o = (v == 65536);
           v = v % 65536;
           th[k] = v / 256;
           tl[k] = v % 256;
         end
      2: if (tl[k] == 255) begin tl[k] = th[k]; o = 1; end
         else tl[k] = tl[k] + 1;
      default: ;
    endcase
  endtask

  task automatic step();
    bit tick, sp, w0, w1, o0, o1, o1h, e1;
    bit ev [2];
    bit inc [2];
    int m [2];
    tick = (pc == MC - 1);
    pc = tick ? 0 : pc + 1;
    for (int k = 0; k < 2; k++) begin
      ev[k] = tick && last[k] && !cnt_pin[k];
      if (tick) last[k] = cnt_pin[k];
      m[k] = int'(cfg[k][1:0]);
      inc[k] = run[k] && (!cfg[k][3] || gate_pin[k]) && (cfg[k][2] ? ev[k] : tick);
    end
    sp = (m[0] == 3);
    w0 = wr_en && (addr == 2 || addr == 3);
    w1 = wr_en && (addr == 4 || addr == 5);
    o0 = 0; o1 = 0; o1h = 0;
    if (w0) begin
      if (addr == 2) tl[0] = int'(wdata); else th[0] = int'(wdata);
    end else if (sp) begin
      if (inc[0]) begin o0 = (tl[0] == 255); tl[0] = (tl[0] + 1) % 256; end
      if (tick && run[1]) begin o1h = (th[0] == 255); th[0] = (th[0] + 1) % 256; end
    end else if (inc[0]) adv(0, m[0], o0);
    if (w1) begin
      if (addr == 4) tl[1] = int'(wdata); else th[1] = int'(wdata);
    end else if (m[1] != 3 && inc[1]) adv(1, m[1], o1);
    e1 = sp ? o1h : o1;
    fl[0] = o0 ? 1'b1 : (ack[0] ? 1'b0 : fl[0]);
    fl[1] = e1 ? 1'b1 : (ack[1] ? 1'b0 : fl[1]);
    if (wr_en && addr == 0) begin cfg[0] = wdata[3:0]; cfg[1] = wdata[7:4]; end
    if (wr_en && addr == 1) begin run[0] = wdata[0]; run[1] = wdata[1]; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc = 0;
      for (int k = 0; k < 2; k++) begin
        last[k] = 0; tl[k] = 0; th[k] = 0; fl[k] = 0; run[k] = 0; cfg[k] = '0;
      end
    end else step();
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {cfg[1], cfg[0]};
      3'd1: return {2'b00, fl[1], fl[0], 2'b00, run[1], run[0]};
      3'd2: return 8'(tl[0]);
      3'd3: return 8'(th[0]);
      3'd4: return 8'(tl[1]);
      3'd5: return 8'(th[1]);
      default: return 8'h00;
    endcase
  endfunction

  // compare every clock, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    n_checks++;
    if (rdata !== exp_rd(addr)) begin
      n_fails++;
      $display("FAIL %s rdata addr=%0d actual=%h expected=%h t=%0t",
               cur_req, addr, rdata, exp_rd(addr), $time);
    end
    n_checks++;
    if (ovf !== {fl[1], fl[0]}) begin
      n_fails++;
      $display("FAIL %s ovf_o actual=%b expected=%b t=%0t",
               cur_req, ovf, {fl[1], fl[0]}, $time);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      wr_en = 1'b0;
      addr  = addr + 3'd1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_ack(input logic [1:0] v);
    @(negedge clk);
    ack = v;
    @(negedge clk);
    ack = '0;
  endtask

  task automatic pin_wave(input int k, input int hi_n, input int lo_n, input int reps);
    repeat (reps) begin
      cnt_pin[k] = 1'b1;
      idle(hi_n);
      cnt_pin[k] = 1'b0;
      idle(lo_n);
    end
  endtask

  initial begin
    #3_000_000;
    n_fails++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    // R12 / R11: reset state and read map
    cur_req = "R11/R12";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(16);
    wr(3'd1, 8'hF0);  // flag bits not writable
    idle(8);

    // R1 / R5: 16-bit timer near wrap
    cur_req = "R1/R5";
    wr(3'd0, 8'h01);
    wr(3'd2, 8'hF0);
    wr(3'd3, 8'hFF);
    wr(3'd1, 8'h01);
    idle(MC * 20);
    cur_req = "R9";
    pulse_ack(2'b01);
    idle(20);

    // R4: 13-bit with upper low bits set
    cur_req = "R4";
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'hFC);
    wr(3'd3, 8'hFF);
    wr(3'd1, 8'h01);
    idle(MC * 40);
    pulse_ack(2'b01);

    // R6: engine 1 reload
    cur_req = "R6";
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h20);
    wr(3'd5, 8'h80);
    wr(3'd4, 8'hFA);
    wr(3'd1, 8'h02);
    idle(MC * 300);
    pulse_ack(2'b10);

    // R2: pin source, several waveforms
    cur_req = "R2";
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h25);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    wr(3'd1, 8'h01);
    pin_wave(0, 24, 24, 10);
    pin_wave(0, 12, 12, 10);
    pin_wave(0, 1, 1, 200);
    pin_wave(0, 5, 7, 50);

    // R3: gate and run
    cur_req = "R3";
    wr(3'd0, 8'h29);
    gate_pin = 2'b00;
    idle(200);
    gate_pin = 2'b01;
    idle(200);
    wr(3'd1, 8'h00);
    idle(200);

    // R7: split engine 0, engine 1 16-bit
    cur_req = "R7";
    wr(3'd0, 8'h13);
    wr(3'd2, 8'hF8);
    wr(3'd3, 8'hF0);
    wr(3'd4, 8'hFF);
    wr(3'd5, 8'hFF);
    wr(3'd1, 8'h03);
    idle(MC * 40);
    pulse_ack(2'b11);
    idle(MC * 10);

    // R8: engine 1 in split encoding holds
    cur_req = "R8";
    wr(3'd0, 8'h31);
    idle(MC * 30);

    // R10: writes against running count
    cur_req = "R10";
    wr(3'd0, 8'h11);
    for (int i = 0; i < 60; i++) wr(3'd2, 8'(i * 7));
    for (int i = 0; i < 60; i++) wr(3'd5, 8'(255 - i));
    idle(MC * 5);

    // R9: random mix with acks
    cur_req = "R9";
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      cnt_pin  = 2'($urandom);
      gate_pin = 2'($urandom);
      ack      = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      if ($urandom % 16 == 0) begin
        wr_en = 1'b1;
        addr  = 3'($urandom % 6);
        wdata = 8'($urandom);
      end else begin
        wr_en = 1'b0;
        addr  = 3'($urandom);
      end
    end
    idle(10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule